// File: doc/BRIEF.md
# Address-Latched Program Bank Mapper

This block sits between an 8-bit console CPU bus and a cartridge's program ROM and character RAM. Any CPU write that lands in the upper half of the address space, from 0x8000 to 0xFFFF, loads the low byte of the write address into a bank register. The written data byte plays no part, so the block has no data input.

The bank register controls two 16KB program windows and the nametable mirroring mode. The lower window, at 0x8000–0xBFFF, always selects an even bank. The upper window, at 0xC000–0xFFFF, selects the same bank with bit 5 of the latched address as its low bit.

The block forms a flat ROM address from the selected 5-bit bank number and the CPU offset. On the video side it passes the address through to a single 8KB character RAM and asserts that RAM's select.

Top module: `addr_latch_mapper`

## Requirements
- R1: After reset, both program windows select bank 0 and `mirror_h` is 0 (vertical).
- R2: On a rising clock edge where `cpu_wr` is 1 and `cpu_addr[15]` is 1, the register takes `cpu_addr[7:0]`. From the next cycle the windows and mirroring follow that value.
- R3: A write with `cpu_addr[15]` = 0, and any cycle with `cpu_wr` = 0, leaves the bank register and `mirror_h` unchanged.
- R4: The lower window bank number is latched bits 4:1 followed by a 0, so it is always even. For example, latched 0x3E gives bank 30.
- R5: The upper window bank number is latched bits 4:1 followed by latched bit 5. For example, latched 0x3E gives bank 31 and latched 0x20 gives bank 1.
- R6: `prg_addr` is {bank, `cpu_addr[13:0]`}, with `cpu_addr[14]` = 1 choosing the upper window. `prg_cs` is 1 exactly when `cpu_addr[15]` = 1 and `cpu_wr` = 0.
- R7: `mirror_h` equals latched address bit 7: 0 for vertical, 1 for horizontal. Successive writes may toggle it either way.
- R8: `chr_addr` equals `ppu_addr[12:0]`, and `chr_cs` is 1 exactly when `ppu_addr[13]` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Video-side address |
| prg_addr | output | 19 | Program ROM byte address |
| prg_cs | output | 1 | Program ROM read select |
| chr_addr | output | 13 | Character RAM address |
| chr_cs | output | 1 | Character RAM select |
| mirror_h | output | 1 | Mirroring: 1 horizontal, 0 vertical |

## Verification
The assertions assume `cpu_addr` and `cpu_wr` are stable across each rising edge. They also assume a write lasts exactly one cycle and that the address seen on that edge is the one to latch. The stimulus changes inputs only on falling edges and raises `cpu_wr` for a single cycle per write. Between writes it holds `cpu_wr` low while it steps read addresses through both windows.

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper #(
  parameter int BANK_W = 5,
  parameter int OFF_W  = 14,
  parameter int CHR_W  = 13,
  parameter int LOW_POS = 5,
  parameter int MIR_POS = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             cpu_addr,
  input  logic                    cpu_wr,
  input  logic [CHR_W:0]          ppu_addr,
  output logic [BANK_W+OFF_W-1:0] prg_addr,
  output logic                    prg_cs,
  output logic [CHR_W-1:0]        chr_addr,
  output logic                    chr_cs,
  output logic                    mirror_h
);
  localparam int LAT_W = MIR_POS + 1;

  logic [LAT_W-1:0]  lat;
  logic [BANK_W-1:0] bank;
  logic              hit;

  assign hit = cpu_wr & cpu_addr[15];

  always_ff @(posedge clk) begin
    if (!rst_n)   lat <= '0;
    else if (hit) lat <= cpu_addr[LAT_W-1:0];
  end

  assign bank     = {lat[BANK_W-1:1], cpu_addr[OFF_W] & lat[LOW_POS]};
  assign prg_addr = {bank, cpu_addr[OFF_W-1:0]};
  assign prg_cs   = cpu_addr[15] & ~cpu_wr;
  assign mirror_h = lat[MIR_POS];
  assign chr_addr = ppu_addr[CHR_W-1:0];
  assign chr_cs   = ~ppu_addr[CHR_W];
endmodule

module addr_latch_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [18:0] prg_addr,
  input logic        prg_cs,
  input logic        mirror_h
);
  a_r2_load_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> prg_addr[18:15] == $past(cpu_addr[4:1]));
  a_r3_hold_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15]) |=> $stable(mirror_h));
  a_r4_lower_even: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_cs && !cpu_addr[14]) |-> !prg_addr[14]);
  a_r5_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> (cpu_addr[14] -> prg_addr[14] == $past(cpu_addr[5])));
  a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> mirror_h == $past(cpu_addr[7]));
endmodule

bind addr_latch_mapper addr_latch_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .prg_addr(prg_addr), .prg_cs(prg_cs), .mirror_h(mirror_h)
);

// File: tb/tb_addr_latch_mapper.sv
module tb_addr_latch_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 0;
  logic [13:0] ppu_addr = '0;
  logic [18:0] prg_addr;
  logic        prg_cs;
  logic [12:0] chr_addr;
  logic        chr_cs;
  logic        mirror_h;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_latch_mapper dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic probe(string req, logic [4:0] lo, logic [4:0] hi, logic mir);
    cpu_addr = 16'h8123; #1;
    check(req, prg_addr, {lo, 14'h0123});
    check("R6", prg_cs, 1);
    cpu_addr = 16'hC3FF; #1;
    check(req, prg_addr, {hi, 14'h03FF});
    check("R7", mirror_h, mir);
  endtask

  task automatic do_write(logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_wr = 1; #1;
    check("R6", prg_cs, 0);
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    probe("R1", 5'd0, 5'd0, 0);
  endtask

  task automatic t_load(logic [15:0] a);
    do_write(a);
    probe("R4", {a[4:1], 1'b0}, {a[4:1], a[5]}, a[7]);
    check("R5", prg_addr[18:14], {a[4:1], a[5]});
    check("R2", prg_addr[18:15], a[4:1]);
  endtask

  task automatic t_ignored();
    do_write(16'h80BE);
    do_write(16'h7F00);
    probe("R3", 5'd30, 5'd31, 1);
    @(negedge clk); cpu_addr = 16'hC000; cpu_wr = 0;
    @(negedge clk);
    probe("R3", 5'd30, 5'd31, 1);
  endtask

  task automatic t_chr();
    ppu_addr = 14'h1FFF; #1;
    check("R8", chr_cs, 1); check("R8", chr_addr, 13'h1FFF);
    ppu_addr = 14'h2000; #1;
    check("R8", chr_cs, 0);
    ppu_addr = 14'h0A5A; #1;
    check("R8", chr_addr, 13'h0A5A);
  endtask

  initial begin
    t_reset();
    t_load(16'h803E);
    t_load(16'h8020);
    t_load(16'h8022);
    t_load(16'hF082);
    t_load(16'h8000);
    t_load(16'hFFFF);
    t_ignored();
    t_chr();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule